// File: doc/BRIEF.md
# Masked Pin-Change and Timer-Wrap Interrupt Flagger

This block watches a digital input port and raises a sticky change flag when an enabled pin takes a new level. A pin counts as a change source only if two conditions hold. Its bit in a software-written mask must be set. The pin must also be configured as a digital input. Each port level first passes through a synchroniser. The synchronised level is then compared with a copy that is captured again on every clock.

The block also holds a small up-counter that advances on a tick strobe and can be loaded by software. When the counter wraps from all ones to zero, it sets a second sticky flag. Each flag has its own enable. Both enabled flags are combined into one interrupt request, and a global enable gates that request. A flag stays set until its clear strobe arrives. If a clear and a new event land in the same cycle, the event wins.

Top module: `pin_change_irq`

## Requirements
- R1: A level change on an eligible pin sets `chg_flag` on the third rising clock edge after the change is applied, and not before.
- R2: A change on a pin whose `mask_q` bit is 0 never sets `chg_flag`.
- R3: A change on a pin whose `pin_is_din` bit is 0 (not a digital input) never sets `chg_flag`, even when its mask bit is 1.
- R4: `chg_flag` and `tmr_flag` stay set until their clear strobe (`chg_clr`, `tmr_clr`) is high at a clock edge. With no new event, the flag reads 0 after that edge.
- R5: If a clear strobe and a new event of the same flag occur at the same edge, the flag is set after that edge.
- R6: At each edge, `tmr_we` loads `tmr_wdata` into `tmr_q`, taking precedence over `tmr_tick`. Otherwise `tmr_tick` adds one to `tmr_q`. A tick while `tmr_q` is all ones gives zero and sets `tmr_flag`. A load never sets it.
- R7: `irq` equals `gie & ((chg_flag & chg_ie) | (tmr_flag & tmr_ie))`. The enables have no effect on whether a flag is set.
- R8: After reset, `chg_flag`, `tmr_flag`, `tmr_q` and `mask_q` are 0. Port levels that are already present when reset is released do not set `chg_flag`.
- R9: `mask_we` high at an edge loads `mask_wdata` into `mask_q`. Otherwise `mask_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | 8 | Asynchronous port pin levels |
| pin_is_din | input | 8 | 1 = pin configured as digital input |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask write data |
| mask_q | output | 8 | Per-pin change-enable mask |
| tmr_tick | input | 1 | Counter advance strobe |
| tmr_we | input | 1 | Counter load strobe |
| tmr_wdata | input | 8 | Counter load value |
| tmr_q | output | 8 | Counter value |
| chg_ie | input | 1 | Port-change interrupt enable |
| tmr_ie | input | 1 | Counter-wrap interrupt enable |
| gie | input | 1 | Global interrupt enable |
| chg_clr | input | 1 | Port-change flag clear strobe |
| tmr_clr | input | 1 | Counter-wrap flag clear strobe |
| chg_flag | output | 1 | Sticky port-change flag |
| tmr_flag | output | 1 | Sticky counter-wrap flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives random port levels every cycle, together with random mask bits and random digital-input configurations. Under these patterns a missing mask or mode gate shows up as a spurious flag, and a wrong synchroniser depth shows up as a flag one cycle early or late against the reference model.

Directed cases cover the following:
- a single toggle, to measure the exact latency;
- a clear landing on the same edge as an event;
- a port held high through reset release;
- counter loads near the wrap point combined with ticks.

These separate a correct design from wrong priority between load and tick, and from false changes caused by reset.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int PORT_W      = 8,
  parameter int TMR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] pin_is_din,
  input  logic              mask_we,
  input  logic [PORT_W-1:0] mask_wdata,
  output logic [PORT_W-1:0] mask_q,
  input  logic              tmr_tick,
  input  logic              tmr_we,
  input  logic [TMR_W-1:0]  tmr_wdata,
  output logic [TMR_W-1:0]  tmr_q,
  input  logic              chg_ie,
  input  logic              tmr_ie,
  input  logic              gie,
  input  logic              chg_clr,
  input  logic              tmr_clr,
  output logic              chg_flag,
  output logic              tmr_flag,
  output logic              irq
);
  localparam int ARM_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0][PORT_W-1:0] sync_q;
  logic [PORT_W-1:0] pin_sync, last_q, chg_vec;
  logic [ARM_W-1:0]  arm_q;
  logic              armed, chg_any, tmr_wrap;

  assign pin_sync = sync_q[SYNC_STAGES-1];
  assign armed    = arm_q[ARM_W-1];
  assign chg_vec  = (pin_sync ^ last_q) & mask_q & pin_is_din;
  assign chg_any  = armed & (|chg_vec);
  assign tmr_wrap = tmr_tick & ~tmr_we & (&tmr_q);
  assign irq      = gie & ((chg_flag & chg_ie) | (tmr_flag & tmr_ie));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= '0;
      arm_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], port_in};
      last_q <= pin_sync;
      arm_q  <= {arm_q[ARM_W-2:0], 1'b1};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        tmr_q <= '0;
    else if (tmr_we)   tmr_q <= tmr_wdata;
    else if (tmr_tick) tmr_q <= tmr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chg_flag <= 1'b0;
      tmr_flag <= 1'b0;
    end else begin
      chg_flag <= chg_any  | (chg_flag & ~chg_clr);
      tmr_flag <= tmr_wrap | (tmr_flag & ~tmr_clr);
    end
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int PORT_W = 8,
  parameter int TMR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gie,
  input logic              chg_clr,
  input logic              tmr_clr,
  input logic              tmr_tick,
  input logic              tmr_we,
  input logic [TMR_W-1:0]  tmr_wdata,
  input logic [TMR_W-1:0]  tmr_q,
  input logic [PORT_W-1:0] mask_q,
  input logic [PORT_W-1:0] pin_is_din,
  input logic              chg_any,
  input logic              chg_flag,
  input logic              tmr_flag,
  input logic              irq
);
  AST_CHG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    chg_flag && !chg_clr |=> chg_flag); // R4
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_flag && !tmr_clr |=> tmr_flag); // R4
  AST_CHG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    chg_clr && !chg_any |=> !chg_flag); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    chg_any |=> chg_flag); // R5
  AST_SRC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_flag) |-> $past(|(mask_q & pin_is_din))); // R2
  AST_TMR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick && !tmr_we && (&tmr_q) |=> tmr_flag && (tmr_q == '0)); // R6
  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> tmr_q == $past(tmr_wdata)); // R6
  AST_IRQ_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq); // R7
endmodule

bind pin_change_irq pin_change_irq_chk #(.PORT_W(PORT_W), .TMR_W(TMR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .gie(gie), .chg_clr(chg_clr), .tmr_clr(tmr_clr),
  .tmr_tick(tmr_tick), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_q(tmr_q),
  .mask_q(mask_q), .pin_is_din(pin_is_din), .chg_any(chg_any),
  .chg_flag(chg_flag), .tmr_flag(tmr_flag), .irq(irq)
);

// File: tb/pin_change_irq_tb_top.sv
module pin_change_irq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] port_in = '0, pin_is_din = '0, mask_wdata = '0, tmr_wdata = '0;
  logic mask_we = 0, tmr_tick = 0, tmr_we = 0, chg_ie = 0, tmr_ie = 0, gie = 0;
  logic chg_clr = 0, tmr_clr = 0;
  logic [7:0] mask_q, tmr_q;
  logic chg_flag, tmr_flag, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_irq dut_i (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .pin_is_din(pin_is_din),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_q(mask_q),
    .tmr_tick(tmr_tick), .tmr_we(tmr_we), .tmr_wdata(tmr_wdata), .tmr_q(tmr_q),
    .chg_ie(chg_ie), .tmr_ie(tmr_ie), .gie(gie), .chg_clr(chg_clr), .tmr_clr(tmr_clr),
    .chg_flag(chg_flag), .tmr_flag(tmr_flag), .irq(irq));

  // reference model built from the requirements
  logic [7:0] m_s1 = 0, m_s2 = 0, m_last = 0, m_mask = 0, m_tmr = 0;
  int         m_age = 0;
  logic       m_cf = 0, m_tf = 0;

  function automatic logic exp_irq(logic cf, logic tf);
    return gie & ((cf & chg_ie) | (tf & tmr_ie));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_last <= 0; m_mask <= 0; m_tmr <= 0;
      m_age <= 0; m_cf <= 0; m_tf <= 0;
    end else begin
      logic ev;
      ev = (m_age >= 3) && (((m_s2 ^ m_last) & m_mask & pin_is_din) != 0);
      m_s1 <= port_in; m_s2 <= m_s1; m_last <= m_s2;
      m_age <= m_age + 1;
      if (mask_we) m_mask <= mask_wdata;
      if (tmr_we) m_tmr <= tmr_wdata;
      else if (tmr_tick) m_tmr <= m_tmr + 8'd1;
      m_cf <= ev | (m_cf & ~chg_clr);
      m_tf <= (tmr_tick & ~tmr_we & (m_tmr == 8'hFF)) | (m_tf & ~tmr_clr);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(chg_flag == m_cf, "R1 chg_flag vs model", chg_flag, m_cf);
    chk(tmr_flag == m_tf, "R6 tmr_flag vs model", tmr_flag, m_tf);
    chk(tmr_q == m_tmr,   "R6 tmr_q vs model", tmr_q, m_tmr);
    chk(mask_q == m_mask, "R9 mask_q vs model", mask_q, m_mask);
    chk(irq == exp_irq(chg_flag, tmr_flag), "R7 irq gating", irq, exp_irq(chg_flag, tmr_flag));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    mask_we = 0; tmr_we = 0; tmr_tick = 0; chg_clr = 0; tmr_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    // R8: port high through reset release
    port_in = 8'hFF; pin_is_din = 8'hFF;
    #(CLK_PERIOD*3);
    @(negedge clk);
    chk(chg_flag == 0 && tmr_flag == 0, "R8 flags in reset", {chg_flag, tmr_flag}, 0);
    chk(tmr_q == 0 && mask_q == 0, "R8 regs in reset", {tmr_q, mask_q}, 0);
    rst_n = 1;
    mask_we = 1; mask_wdata = 8'hFF;
    step();
    for (int i = 0; i < 6; i++) step();
    chk(chg_flag == 0, "R8 no change from initial port level", chg_flag, 0);
    chk(mask_q == 8'hFF, "R9 mask write", mask_q, 8'hFF);

    // R1: latency of a single toggle
    port_in = 8'hFE;
    step(); step();
    chk(chg_flag == 0, "R1 not before third edge", chg_flag, 0);
    step();
    chk(chg_flag == 1, "R1 set at third edge", chg_flag, 1);
    // R4: sticky, then cleared
    for (int i = 0; i < 4; i++) step();
    chk(chg_flag == 1, "R4 flag stays set", chg_flag, 1);
    chg_clr = 1; step();
    chk(chg_flag == 0, "R4 clear strobe", chg_flag, 0);

    // R5: clear on the same edge as a new event
    port_in = 8'hFF;
    step(); step();
    chg_clr = 1; step();
    chk(chg_flag == 1, "R5 event beats clear", chg_flag, 1);
    chg_clr = 1; step();

    // R2: masked pin ignored
    mask_we = 1; mask_wdata = 8'h7F; step();
    port_in = 8'h7F;
    for (int i = 0; i < 5; i++) step();
    chk(chg_flag == 0, "R2 masked pin ignored", chg_flag, 0);
    // R3: non-digital pin ignored
    pin_is_din = 8'hFE; port_in = 8'h7E;
    for (int i = 0; i < 5; i++) step();
    chk(chg_flag == 0, "R3 non-digital pin ignored", chg_flag, 0);
    pin_is_din = 8'hFF;

    // R6: load precedence, wrap, load of all ones does not flag
    tmr_we = 1; tmr_tick = 1; tmr_wdata = 8'hFE; step();
    chk(tmr_q == 8'hFE, "R6 load beats tick", tmr_q, 8'hFE);
    tmr_tick = 1; step();
    chk(tmr_flag == 0 && tmr_q == 8'hFF, "R6 no flag before wrap", {tmr_flag, tmr_q}, 9'h0FF);
    tmr_tick = 1; step();
    chk(tmr_flag == 1 && tmr_q == 0, "R6 wrap sets flag", {tmr_flag, tmr_q}, 9'h100);
    // R7: enables
    gie = 1; tmr_ie = 0; step();
    chk(irq == 0, "R7 disabled source quiet", irq, 0);
    tmr_ie = 1; #1;
    chk(irq == 1, "R7 enabled source requests", irq, 1);
    gie = 0; #1;
    chk(irq == 0, "R7 global gate", irq, 0);
    tmr_clr = 1; step();
    tmr_we = 1; tmr_wdata = 8'hFF; tmr_tick = 1; step();
    chk(tmr_flag == 0, "R6 load never flags", tmr_flag, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      port_in    = $urandom;
      if ($urandom_range(0, 15) == 0) pin_is_din = $urandom;
      mask_we    = ($urandom_range(0, 19) == 0); mask_wdata = $urandom;
      tmr_tick   = $urandom_range(0, 1);
      tmr_we     = ($urandom_range(0, 31) == 0);
      tmr_wdata  = ($urandom_range(0, 1) != 0) ? 8'hFD : 8'($urandom);
      chg_clr    = ($urandom_range(0, 5) == 0);
      tmr_clr    = ($urandom_range(0, 5) == 0);
      chg_ie = $urandom_range(0, 1); tmr_ie = $urandom_range(0, 1); gie = $urandom_range(0, 1);
      @(negedge clk);
      compare_all();
    end
    finish_run();
  end
endmodule